// File: doc/BRIEF.md
# Debug Slot Fire Qualifier

This block takes the per-slot hit vector from an address comparator that serves a bank of hardware breakpoint and watchpoint slots. It decides which of those hits should really raise a debug event, given the context the access ran in. Each slot owns a control word and a value word, loaded through a simple write port. The control word says which exception levels the slot may fire at, which security state it accepts, and whether it also needs a companion context-ID slot to agree. A separate pair of inputs can mute every slot at once: a global debug-enable bit and a flag saying debug exceptions may be taken in the current state.

For each access the block looks at the hit slots in ascending order and reports the lowest-numbered slot whose conditions all hold. One cycle after the access is sampled, it presents a valid strobe, a fire flag and the slot index. The bank has up to 16 slots. Two elaboration parameters bound the link targets: `BRP_TOP`, the index of the highest implemented breakpoint, and `CTX_CNT`, the number of context-aware slots that sit directly below it.

Top module: `dbg_fire_matcher`

## Requirements
- R1: During and after reset, before the first access, `fire_valid`, `fire` and `fire_idx` are all 0, and every control and value word reads as 0.
- R2: `fire_valid` is 1 exactly in the cycle after a cycle with `acc_valid` = 1. `fire` is never 1 without `fire_valid`.
- R3: When `dbg_glb_en` = 0 or `dbg_allowed` = 0 at the sampled access, `fire` is 0 whatever the slot state.
- R4: A slot can qualify only if its `acc_hit` bit is 1 and bit 0 (enable) of its control word is 1.
- R5: The security filter at control bits [15:14] works as follows: 0 accepts both states, 1 and 3 accept only `acc_secure` = 0, and 2 accepts only `acc_secure` = 1.
- R6: At effective level 2 or 3 the slot needs control bit 13. At level 1 it needs control bit 1. At level 0 it needs control bit 2.
- R7: With `acc_unpriv` = 1, the level check of R6 uses level 0 whatever `acc_el` holds.
- R8: With control bit 20 (link flag) set, the slot named by control bits [19:16] must lie in the range BRP_TOP−CTX_CNT to BRP_TOP inclusive. Outside that range the link fails.
- R9: A link target must have its own bit 0 set and its bits [23:20] equal to 3. Any other value in that field makes the link fail.
- R10: A link succeeds only if the real `acc_el` is below 2 and `acc_ctxid` equals the low CTX_W bits of the target's value word. `acc_unpriv` does not change this level test.
- R11: When several slots qualify, `fire_idx` is the lowest qualifying index. When `fire` is 0, `fire_idx` is 0.
- R12: A write with `cfg_val_sel` = 0 loads the control word and with 1 loads the value word of slot `cfg_slot`. An access sampled on the same edge as a write still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Slot register write strobe |
| cfg_val_sel | input | 1 | 0 selects the control word, 1 the value word |
| cfg_slot | input | IDXW | Slot written |
| cfg_wdata | input | DATA_W | Write data |
| acc_valid | input | 1 | Access inputs are valid this cycle |
| acc_hit | input | N_SLOTS | Address-match vector, one bit per slot |
| acc_el | input | 2 | Current exception level |
| acc_secure | input | 1 | Secure state |
| acc_unpriv | input | 1 | Access is an unprivileged load/store |
| acc_ctxid | input | CTX_W | Current context ID |
| dbg_glb_en | input | 1 | Global debug enable |
| dbg_allowed | input | 1 | Debug exceptions may be taken |
| fire_valid | output | 1 | Result strobe, one cycle after `acc_valid` |
| fire | output | 1 | A slot qualifies |
| fire_idx | output | IDXW | Lowest qualifying slot |

## Verification
The hardest case to reach is a linked slot. It fires only when two slot registers, the real exception level and the context ID all agree, and when the link index falls inside a window set by parameters. The bench first loads every upper slot as a context-ID target with a distinct value word. It then walks the link index across all 16 codes and the target's kind and enable across all 32 combinations. Last, it crosses real level with the unprivileged flag, so that an unprivileged access at a high level passes the level check but still fails the link. A same-edge write and access shows that an access only sees a new register value from the following cycle.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
   // control word field positions (decoded by the qualifier and link logic)
   localparam int EN_BIT     = 0;
   localparam int EL1_OK_BIT = 1;
   localparam int EL0_OK_BIT = 2;
   localparam int HI_OK_BIT  = 13;
   localparam int SEC_LO     = 14;
   localparam int LSLOT_LO   = 16;
   localparam int LINK_BIT   = 20;
   localparam int KIND_LO    = 20;
   localparam int CTRL_MSB   = 23;
   localparam logic [3:0] KIND_CTX = 4'd3;

   typedef enum logic [1:0] {
      SEC_ANY   = 2'd0,
      SEC_NS_A  = 2'd1,
      SEC_SONLY = 2'd2,
      SEC_NS_B  = 2'd3
   } sec_filter_e;
endpackage

// File: rtl/dbgm_slot_regs.sv
module dbgm_slot_regs
   import dbgm_pkg::*;
#(
   parameter int N_SLOTS = 16,
   parameter int DATA_W  = 32,
   parameter int IDXW    = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic                           val_sel,
   input  logic [IDXW-1:0]                slot,
   input  logic [DATA_W-1:0]              wdata,
   output logic [N_SLOTS-1:0][DATA_W-1:0] ctrl_q,
   output logic [N_SLOTS-1:0][DATA_W-1:0] val_q
);
   for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
      logic [DATA_W-1:0] c_r;
      logic [DATA_W-1:0] v_r;
      logic              sel_k;

      assign sel_k = we && (slot == IDXW'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_r <= '0;
            v_r <= '0;
         end else if (sel_k) begin
            if (val_sel) v_r <= wdata;
            else         c_r <= wdata;
         end
      end

      assign ctrl_q[k] = c_r;
      assign val_q[k]  = v_r;

      // R12: a control write lands on the following edge
      assert_cfg_ctrl_R12: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(we) && !$past(val_sel) && ($past(slot) == IDXW'(k))
         |-> c_r == $past(wdata));
      // R12: a value write lands on the following edge
      assert_cfg_val_R12: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(we) && $past(val_sel) && ($past(slot) == IDXW'(k))
         |-> v_r == $past(wdata));
   end
endmodule

// File: rtl/dbgm_link_eval.sv
module dbgm_link_eval
   import dbgm_pkg::*;
#(
   parameter int N_SLOTS = 16,
   parameter int DATA_W  = 32,
   parameter int CTX_W   = 32,
   parameter int BRP_TOP = 13,
   parameter int CTX_CNT = 2
) (
   input  logic [N_SLOTS-1:0][DATA_W-1:0] ctrl_q,
   input  logic [N_SLOTS-1:0][DATA_W-1:0] val_q,
   input  logic [1:0]                     cur_el,
   input  logic [CTX_W-1:0]               ctxid,
   output logic [15:0]                    link_ok
);
   localparam int LINK_LO = BRP_TOP - CTX_CNT;

   logic unused_words;
   assign unused_words = ^{ctrl_q, val_q};

   for (genvar j = 0; j < 16; j++) begin : g_tgt
      if (j < N_SLOTS && j >= LINK_LO && j <= BRP_TOP) begin : g_ctx
         logic kind_ok;
         logic id_ok;
         assign kind_ok = ctrl_q[j][EN_BIT] && (ctrl_q[j][KIND_LO +: 4] == KIND_CTX);
         assign id_ok   = (ctxid == val_q[j][CTX_W-1:0]);
         assign link_ok[j] = kind_ok && id_ok && !cur_el[1];
      end else begin : g_none
         assign link_ok[j] = 1'b0;
      end
   end

   // R10: no link target may match from level 2 or above
   always_comb begin
      if (cur_el[1]) assert_no_ctx_high_el_R10: assert (link_ok == '0);
   end
endmodule

// File: rtl/dbgm_slot_qual.sv
module dbgm_slot_qual
   import dbgm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] ctrl,
   input  logic              hit,
   input  logic [1:0]        eff_el,
   input  logic              secure,
   input  logic [15:0]       link_vec,
   output logic              qual
);
   logic        sec_ok;
   logic        lvl_ok;
   logic        lnk_ok;
   logic [3:0]  lslot;
   sec_filter_e sfilt;
   logic        unused_ctrl;

   assign unused_ctrl = ^ctrl;
   assign sfilt = sec_filter_e'(ctrl[SEC_LO +: 2]);
   assign lslot = ctrl[LSLOT_LO +: 4];

   always_comb begin
      unique case (sfilt)
         SEC_ANY:            sec_ok = 1'b1;
         SEC_SONLY:          sec_ok = secure;
         SEC_NS_A, SEC_NS_B: sec_ok = !secure;
         default:            sec_ok = 1'b0;
      endcase
   end

   always_comb begin
      unique case (eff_el)
         2'd0:    lvl_ok = ctrl[EL0_OK_BIT];
         2'd1:    lvl_ok = ctrl[EL1_OK_BIT];
         default: lvl_ok = ctrl[HI_OK_BIT];
      endcase
   end

   assign lnk_ok = ctrl[LINK_BIT] ? link_vec[lslot] : 1'b1;
   assign qual   = hit && ctrl[EN_BIT] && sec_ok && lvl_ok && lnk_ok;

   // R5: a secure-only slot never qualifies for a non-secure access
   always_comb begin
      if (sfilt == SEC_SONLY && !secure) assert_secure_only_R5: assert (!qual);
   end
endmodule

// File: rtl/dbgm_prio_pick.sv
module dbgm_prio_pick #(
   parameter int N_SLOTS = 16,
   parameter int IDXW    = 4
) (
   input  logic [N_SLOTS-1:0] req,
   output logic               any,
   output logic [IDXW-1:0]    idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N_SLOTS - 1; i >= 0; i--) begin
         if (req[i]) idx = IDXW'(i);
      end
   end
endmodule

// File: rtl/dbg_fire_matcher.sv
module dbg_fire_matcher
   import dbgm_pkg::*;
#(
   parameter int N_SLOTS = 16,
   parameter int DATA_W  = 32,
   parameter int CTX_W   = 32,
   parameter int BRP_TOP = 13,
   parameter int CTX_CNT = 2,
   localparam int IDXW   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_val_sel,
   input  logic [IDXW-1:0]    cfg_slot,
   input  logic [DATA_W-1:0]  cfg_wdata,
   input  logic               acc_valid,
   input  logic [N_SLOTS-1:0] acc_hit,
   input  logic [1:0]         acc_el,
   input  logic               acc_secure,
   input  logic               acc_unpriv,
   input  logic [CTX_W-1:0]   acc_ctxid,
   input  logic               dbg_glb_en,
   input  logic               dbg_allowed,
   output logic               fire_valid,
   output logic               fire,
   output logic [IDXW-1:0]    fire_idx
);
   if (N_SLOTS < 1 || N_SLOTS > 16) begin : g_bad_n
      $error("N_SLOTS must lie in 1..16");
   end
   if (DATA_W <= CTRL_MSB || CTX_W > DATA_W) begin : g_bad_w
      $error("DATA_W must cover the control fields and CTX_W");
   end
   if (BRP_TOP >= N_SLOTS || CTX_CNT < 0) begin : g_bad_lnk
      $error("link window parameters out of range");
   end

   logic [N_SLOTS-1:0][DATA_W-1:0] ctrl_q;
   logic [N_SLOTS-1:0][DATA_W-1:0] val_q;
   logic [15:0]                    link_ok;
   logic [N_SLOTS-1:0]             qual;
   logic [1:0]                     eff_el;
   logic                           any_q;
   logic [IDXW-1:0]                pick_idx;
   logic                           gate;
   logic                           fire_d;

   dbgm_slot_regs #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W), .IDXW(IDXW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .val_sel(cfg_val_sel),
      .slot(cfg_slot), .wdata(cfg_wdata), .ctrl_q(ctrl_q), .val_q(val_q)
   );

   dbgm_link_eval #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W), .CTX_W(CTX_W),
                    .BRP_TOP(BRP_TOP), .CTX_CNT(CTX_CNT)) u_link (
      .ctrl_q(ctrl_q), .val_q(val_q), .cur_el(acc_el), .ctxid(acc_ctxid),
      .link_ok(link_ok)
   );

   assign eff_el = acc_unpriv ? 2'd0 : acc_el;

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_qual
      dbgm_slot_qual #(.DATA_W(DATA_W)) u_q (
         .ctrl(ctrl_q[s]), .hit(acc_hit[s]), .eff_el(eff_el),
         .secure(acc_secure), .link_vec(link_ok), .qual(qual[s])
      );
   end

   dbgm_prio_pick #(.N_SLOTS(N_SLOTS), .IDXW(IDXW)) u_pick (
      .req(qual), .any(any_q), .idx(pick_idx)
   );

   assign gate   = dbg_glb_en && dbg_allowed;
   assign fire_d = acc_valid && gate && any_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fire_valid <= 1'b0;
         fire       <= 1'b0;
         fire_idx   <= '0;
      end else begin
         fire_valid <= acc_valid;
         fire       <= fire_d;
         fire_idx   <= fire_d ? pick_idx : '0;
      end
   end

   // R2: strobe follows a sampled access by one cycle
   assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(acc_valid) |-> fire_valid);
   assert_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(acc_valid) |-> !fire_valid && !fire);
   // R3: muted accesses never fire
   assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid) && !($past(dbg_glb_en) && $past(dbg_allowed)) |-> !fire);
   // R4: the reported slot was hit
   assert_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (($past(acc_hit) >> fire_idx) & N_SLOTS'(1)) != '0);
   // R11: index is zero when nothing fires
   assert_idle_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |-> fire_idx == '0);
endmodule

// File: tb/dbg_fire_matcher_tb_top.sv
module dbg_fire_matcher_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_val_sel = 1'b0;
   logic [3:0]  cfg_slot = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [15:0] acc_hit = '0;
   logic [1:0]  acc_el = '0;
   logic        acc_secure = 1'b0;
   logic        acc_unpriv = 1'b0;
   logic [31:0] acc_ctxid = '0;
   logic        dbg_glb_en = 1'b1;
   logic        dbg_allowed = 1'b1;
   logic        fire_valid;
   logic        fire;
   logic [3:0]  fire_idx;

   int compared = 0;
   int mismatched = 0;
   logic [31:0] sc [16];
   logic [31:0] sv [16];

   always #(CLK_PERIOD / 2) clk = ~clk;

   dbg_fire_matcher dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_val_sel(cfg_val_sel),
      .cfg_slot(cfg_slot), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
      .acc_hit(acc_hit), .acc_el(acc_el), .acc_secure(acc_secure),
      .acc_unpriv(acc_unpriv), .acc_ctxid(acc_ctxid), .dbg_glb_en(dbg_glb_en),
      .dbg_allowed(dbg_allowed), .fire_valid(fire_valid), .fire(fire),
      .fire_idx(fire_idx)
   );

   // expected qualification of one slot, from the requirements
   function automatic bit slot_ok(int s, logic [15:0] hv, int el, bit sec,
                                  bit unp, logic [31:0] ctx);
      logic [31:0] c;
      logic [31:0] lc;
      int eff;
      int lbn;
      c = sc[s];
      if (!hv[s] || !c[0]) return 1'b0;                       // R4
      if ((c[15:14] == 2'd1 || c[15:14] == 2'd3) && sec) return 1'b0; // R5
      if (c[15:14] == 2'd2 && !sec) return 1'b0;
      eff = unp ? 0 : el;                                     // R7
      if (eff >= 2 && !c[13]) return 1'b0;                    // R6
      if (eff == 1 && !c[1]) return 1'b0;
      if (eff == 0 && !c[2]) return 1'b0;
      if (c[20]) begin
         lbn = int'(c[19:16]);
         if (lbn > 13 || lbn < 11) return 1'b0;               // R8
         lc = sc[lbn];
         if (!lc[0] || lc[23:20] != 4'd3) return 1'b0;        // R9
         if (el >= 2) return 1'b0;                            // R10
         if (ctx != sv[lbn]) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic wr(input int s, input bit vsel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_val_sel = vsel; cfg_slot = 4'(s); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (vsel) sv[s] = d; else sc[s] = d;
   endtask

   task automatic check(input bit ev, input bit ef, input int ei, input string tag);
      compared++;
      if (fire_valid !== ev || fire !== ef || fire_idx !== 4'(ei)) begin
         mismatched++;
         $display("FAIL %s: valid/fire/idx got %0b/%0b/%0d expected %0b/%0b/%0d",
                  tag, fire_valid, fire, fire_idx, ev, ef, ei);
      end
   endtask

   task automatic access(input logic [15:0] hv, input int el, input bit sec,
                         input bit unp, input logic [31:0] ctx, input bit glb,
                         input bit alw, input string tag);
      bit ef;
      int ei;
      ef = 1'b0; ei = 0;
      if (glb && alw) begin
         for (int s = 15; s >= 0; s--) begin
            if (slot_ok(s, hv, el, sec, unp, ctx)) begin ef = 1'b1; ei = s; end
         end
      end
      @(negedge clk);
      acc_valid = 1'b1; acc_hit = hv; acc_el = 2'(el); acc_secure = sec;
      acc_unpriv = unp; acc_ctxid = ctx; dbg_glb_en = glb; dbg_allowed = alw;
      @(negedge clk);
      acc_valid = 1'b0;
      check(1'b1, ef, ei, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin sc[i] = '0; sv[i] = '0; end
      repeat (3) @(negedge clk);
      check(1'b0, 1'b0, 0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(1'b0, 1'b0, 0, "R1 after reset");
      // R1: all registers zero, so a full hit with permissive context fires nothing
      access(16'hFFFF, 1, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, "R1 empty slots");

      // R5 R6 R7: exhaustive filter sweep on slot 0
      for (int ssc = 0; ssc < 4; ssc++)
         for (int pac = 0; pac < 4; pac++)
            for (int hm = 0; hm < 2; hm++) begin
               wr(0, 1'b0, 32'(1 | (pac << 1) | (hm << 13) | (ssc << 14)));
               for (int el = 0; el < 4; el++)
                  for (int sec = 0; sec < 2; sec++)
                     for (int unp = 0; unp < 2; unp++)
                        access(16'h0001, el, sec[0], unp[0], 32'h0, 1'b1, 1'b1,
                               "R5 R6 R7 filter");
            end
      wr(0, 1'b0, 32'h0);

      // R2: idle cycle carries no strobe
      @(negedge clk);
      check(1'b0, 1'b0, 0, "R2 idle");

      // R8: link window sweep with every upper slot a context target
      for (int j = 2; j < 16; j++) begin
         wr(j, 1'b0, 32'h0030_0001);
         wr(j, 1'b1, 32'h5A00_0000 + 32'(j));
      end
      for (int l = 0; l < 16; l++) begin
         wr(1, 1'b0, 32'(1 | 6 | (1 << 13) | (1 << 20) | (l << 16)));
         access(16'h0002, 1, 1'b0, 1'b0, sv[l], 1'b1, 1'b1, "R8 link window");
         access(16'h0002, 0, 1'b1, 1'b0, sv[l], 1'b1, 1'b1, "R8 link window el0");
      end

      // R9: target kind and enable sweep
      wr(1, 1'b0, 32'(1 | 6 | (1 << 13) | (1 << 20) | (12 << 16)));
      for (int t = 0; t < 16; t++)
         for (int en = 0; en < 2; en++) begin
            wr(12, 1'b0, 32'(en | (t << 20)));
            access(16'h0002, 0, 1'b0, 1'b0, sv[12], 1'b1, 1'b1, "R9 target kind");
         end
      wr(12, 1'b0, 32'h0030_0001);

      // R10: real level versus unprivileged flag, match and mismatch
      wr(12, 1'b1, 32'hC0DE_1234);
      for (int el = 0; el < 4; el++)
         for (int unp = 0; unp < 2; unp++) begin
            access(16'h0002, el, 1'b0, unp[0], 32'hC0DE_1234, 1'b1, 1'b1, "R10 ctx match");
            access(16'h0002, el, 1'b0, unp[0], 32'hC0DE_1235, 1'b1, 1'b1, "R10 ctx mismatch");
         end

      // R11: priority among slots 4..7 with differing filters
      wr(4, 1'b0, 32'h0000_0005);
      wr(5, 1'b0, 32'h0000_0003);
      wr(6, 1'b0, 32'(1 | (1 << 13) | (2 << 14)));
      wr(7, 1'b0, 32'(1 | 6 | (1 << 13)));
      for (int p = 0; p < 16; p++)
         for (int el = 0; el < 4; el++)
            for (int sec = 0; sec < 2; sec++)
               access(16'(p << 4), el, sec[0], 1'b0, 32'h0, 1'b1, 1'b1, "R11 priority");

      // R3: global mute combinations
      for (int g = 0; g < 4; g++)
         access(16'h0080, 1, 1'b0, 1'b0, 32'h0, g[0], g[1], "R3 gate");

      // R4: slot hit but disabled
      wr(7, 1'b0, 32'(6 | (1 << 13)));
      access(16'h0080, 1, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, "R4 disabled slot");

      // R12: write and access on the same edge
      @(negedge clk);
      cfg_we = 1'b1; cfg_val_sel = 1'b0; cfg_slot = 4'd8;
      cfg_wdata = 32'(1 | 6 | (1 << 13));
      acc_valid = 1'b1; acc_hit = 16'h0100; acc_el = 2'd1; acc_secure = 1'b0;
      acc_unpriv = 1'b0; dbg_glb_en = 1'b1; dbg_allowed = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; acc_valid = 1'b0;
      check(1'b1, 1'b0, 0, "R12 same-edge old value");
      sc[8] = 32'(1 | 6 | (1 << 13));
      access(16'h0100, 1, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, "R12 new value");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule